// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decode

This block is the test access port of a synchronous memory device. A four-wire serial port (test clock, mode select, serial in, serial out, plus an optional asynchronous reset) steps a sixteen-state controller. The controller either moves a 3-bit instruction through a shift stage or moves data through one of three data registers. The data registers are a 32-bit identification register, a one-bit pass-through register, and a boundary register whose cells observe the device pins.

The active instruction is decoded into three things: which data register sits between serial in and serial out, a pin-mux select that lets the boundary register drive the core's output pins, and a force-high-impedance control for every output. The instruction that drives pins does not block the core's input pins. The core keeps seeing its real inputs, so no input-side override exists. A pattern can be preloaded with the non-intrusive sampling instruction and then applied by switching to the pin-driving instruction.

Top module: `scan_port_ctrl`

## Requirements
- R1: Driving `trst_n` low puts the controller in the reset state at once. The active instruction becomes the identify opcode 3'b001, and `ovr_sel`, `force_hiz` and `tdo_oe` all read 0.
- R2: Five rising test-clock edges with `tms` high reach the reset state from any state. At the following falling edge the active instruction returns to the identify opcode, which clears any override.
- R3: When the instruction path captures, the shift stage loads 3'b001. Its bits leave on `tdo` least significant first.
- R4: Under the identify opcode 3'b001, a data capture loads `ID_VALUE`. A data scan then shifts it out least significant bit first.
- R5: The pass-through opcode 3'b111 and the unassigned opcodes 3'b011, 3'b101 and 3'b110 all select a one-bit register that captures 0. Serial input therefore reappears on `tdo` one shift later.
- R6: The sampling opcode 3'b100 captures `pin_sense` into boundary cells [N_PIN-1:0] and `FIX_VALUE` into the cells above them. It shifts the boundary register and leaves `ovr_sel` and `force_hiz` at 0. Its data update loads the hold stage for later use.
- R7: The pin-driving opcode 3'b000 raises `ovr_sel` at the falling test-clock edge in the instruction-update state, not before. `ovr_val` then carries hold cells [N_DRV-1:0], and each data update under this opcode refreshes them.
- R8: Under opcode 3'b000, a data capture loads the pin states and fixed defaults exactly as in R6, and the boundary register scans out.
- R9: The high-impedance opcode 3'b010 raises `force_hiz` at the falling edge in the instruction-update state. It places the boundary register (same capture as R6) between `tdi` and `tdo` and keeps `ovr_sel` at 0.
- R10: `tdo` and `tdo_oe` change only on falling test-clock edges. `tdo_oe` is 1 only while the controller is in one of the two shift states.
- R11: The active instruction changes only at the falling edge in the instruction-update state or in the reset state. Shifting a new opcode alone leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising test clock |
| tdi | input | 1 | Serial data in |
| pin_sense | input | N_PIN | Parallel state of the input and I/O pins |
| tdo | output | 1 | Serial data out, updated on falling test clock |
| tdo_oe | output | 1 | Drive enable for the serial output pad |
| ovr_sel | output | 1 | Pin-mux select: output pins take `ovr_val` |
| ovr_val | output | N_DRV | Override values for the driven output pins |
| force_hiz | output | 1 | Forces every device output to high impedance |

## Verification
A shifted bit is valid on `tdo` from the falling edge of the cycle in which the controller sits in a shift state. The bench samples one time unit after each falling edge and pairs that sample with the bit that moves at the next rising edge. Instruction-driven outputs (`ovr_sel`, `force_hiz`) are sampled twice around the update state: once just after the rising edge that enters it, when the old value is still due, and once just after the following falling edge, when the new value is due. Every expected word is queued by the driver before its scan starts, and a monitor pairs it with the observed word in order.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
    ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
  } tap_state_e;

  localparam int OP_W = 3;
  typedef logic [OP_W-1:0] opcode_t;

  localparam opcode_t OP_DRIVE   = 3'b000;
  localparam opcode_t OP_IDENT   = 3'b001;
  localparam opcode_t OP_HIZ     = 3'b010;
  localparam opcode_t OP_SAMPLE  = 3'b100;
  localparam opcode_t OP_PASS    = 3'b111;
  localparam opcode_t IR_CAPTURE = 3'b001;

  typedef enum logic [1:0] { DR_PASS, DR_IDENT, DR_CELLS } dr_sel_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    case (s)
      ST_RESET:    return m ? ST_RESET    : ST_IDLE;
      ST_IDLE:     return m ? ST_DR_SEL   : ST_IDLE;
      ST_DR_SEL:   return m ? ST_IR_SEL   : ST_DR_CAP;
      ST_DR_CAP:   return m ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_SHIFT: return m ? ST_DR_EXIT1 : ST_DR_SHIFT;
      ST_DR_EXIT1: return m ? ST_DR_UPD   : ST_DR_PAUSE;
      ST_DR_PAUSE: return m ? ST_DR_EXIT2 : ST_DR_PAUSE;
      ST_DR_EXIT2: return m ? ST_DR_UPD   : ST_DR_SHIFT;
      ST_DR_UPD:   return m ? ST_DR_SEL   : ST_IDLE;
      ST_IR_SEL:   return m ? ST_RESET    : ST_IR_CAP;
      ST_IR_CAP:   return m ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_SHIFT: return m ? ST_IR_EXIT1 : ST_IR_SHIFT;
      ST_IR_EXIT1: return m ? ST_IR_UPD   : ST_IR_PAUSE;
      ST_IR_PAUSE: return m ? ST_IR_EXIT2 : ST_IR_PAUSE;
      ST_IR_EXIT2: return m ? ST_IR_UPD   : ST_IR_SHIFT;
      default:     return m ? ST_DR_SEL   : ST_IDLE;
    endcase
  endfunction

  // Unlisted opcodes fall through to the one-bit pass register.
  function automatic dr_sel_e dr_decode(input opcode_t op);
    case (op)
      OP_DRIVE, OP_HIZ, OP_SAMPLE: return DR_CELLS;
      OP_IDENT:                    return DR_IDENT;
      default:                     return DR_PASS;
    endcase
  endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e st_q
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) st_q <= ST_RESET;
    else         st_q <= tap_next(st_q, tms);
  end

endmodule

// File: rtl/scan_ireg.sv
module scan_ireg
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e st_q,
  input  logic       tdi,
  output opcode_t    ir_sr,
  output opcode_t    ir_act
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 ir_sr <= IR_CAPTURE;
    else if (st_q == ST_IR_CAP)   ir_sr <= IR_CAPTURE;
    else if (st_q == ST_IR_SHIFT) ir_sr <= {tdi, ir_sr[OP_W-1:1]};
  end

  // Active instruction moves on the falling edge only.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                ir_act <= OP_IDENT;
    else if (st_q == ST_RESET)  ir_act <= OP_IDENT;
    else if (st_q == ST_IR_UPD) ir_act <= ir_sr;
  end

endmodule

// File: rtl/scan_dregs.sv
module scan_dregs
  import scan_pkg::*;
#(
  parameter int                N_PIN     = 8,
  parameter int                N_FIX     = 2,
  parameter int                N_DRV     = 4,
  parameter int                ID_W      = 32,
  parameter logic [N_FIX-1:0]  FIX_VALUE = '0,
  parameter logic [ID_W-1:0]   ID_VALUE  = 32'h0000_0001
) (
  input  logic             tck,
  input  logic             trst_n,
  input  tap_state_e       st_q,
  input  dr_sel_e          dr_sel,
  input  logic             tdi,
  input  logic [N_PIN-1:0] pin_sense,
  output logic             byp_q,
  output logic             id_lsb,
  output logic             cell_lsb,
  output logic [N_DRV-1:0] hold_q
);

  localparam int N_CELL = N_PIN + N_FIX;

  logic [N_CELL-1:0] cell_q;
  logic [N_CELL-1:0] cell_cap;
  logic [ID_W-1:0]   id_q;

  wire dr_capture = (st_q == ST_DR_CAP);
  wire dr_shift   = (st_q == ST_DR_SHIFT);

  genvar gi;
  generate
    for (gi = 0; gi < N_CELL; gi++) begin : g_cap
      if (gi < N_PIN) begin : g_pin
        assign cell_cap[gi] = pin_sense[gi];
      end else begin : g_fixed
        assign cell_cap[gi] = FIX_VALUE[gi-N_PIN];
      end
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      byp_q  <= 1'b0;
      id_q   <= ID_VALUE;
      cell_q <= '0;
    end else begin
      case (dr_sel)
        DR_PASS: begin
          if (dr_capture)    byp_q <= 1'b0;
          else if (dr_shift) byp_q <= tdi;
        end
        DR_IDENT: begin
          if (dr_capture)    id_q <= ID_VALUE;
          else if (dr_shift) id_q <= {tdi, id_q[ID_W-1:1]};
        end
        default: begin
          if (dr_capture)    cell_q <= cell_cap;
          else if (dr_shift) cell_q <= {tdi, cell_q[N_CELL-1:1]};
        end
      endcase
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)
      hold_q <= '0;
    else if (st_q == ST_DR_UPD && dr_sel == DR_CELLS)
      hold_q <= cell_q[N_DRV-1:0];
  end

  assign id_lsb   = id_q[0];
  assign cell_lsb = cell_q[0];

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_pkg::*;
#(
  parameter int                N_PIN     = 8,
  parameter int                N_FIX     = 2,
  parameter int                N_DRV     = 4,
  parameter int                ID_W      = 32,
  parameter logic [N_FIX-1:0]  FIX_VALUE = 2'b10,
  parameter logic [ID_W-1:0]   ID_VALUE  = 32'h1A5C_E0B3
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  input  logic [N_PIN-1:0] pin_sense,
  output logic             tdo,
  output logic             tdo_oe,
  output logic             ovr_sel,
  output logic [N_DRV-1:0] ovr_val,
  output logic             force_hiz
);

  tap_state_e st_q;
  opcode_t    ir_sr;
  opcode_t    ir_act;
  dr_sel_e    dr_sel;
  logic       byp_q;
  logic       id_lsb;
  logic       cell_lsb;
  logic       dr_lsb;
  logic       in_shift;

  scan_fsm fsm_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .st_q(st_q)
  );

  scan_ireg ireg_i (
    .tck(tck), .trst_n(trst_n), .st_q(st_q), .tdi(tdi),
    .ir_sr(ir_sr), .ir_act(ir_act)
  );

  assign dr_sel = dr_decode(ir_act);

  scan_dregs #(
    .N_PIN(N_PIN), .N_FIX(N_FIX), .N_DRV(N_DRV), .ID_W(ID_W),
    .FIX_VALUE(FIX_VALUE), .ID_VALUE(ID_VALUE)
  ) dregs_i (
    .tck(tck), .trst_n(trst_n), .st_q(st_q), .dr_sel(dr_sel), .tdi(tdi),
    .pin_sense(pin_sense), .byp_q(byp_q), .id_lsb(id_lsb),
    .cell_lsb(cell_lsb), .hold_q(ovr_val)
  );

  always_comb begin
    case (dr_sel)
      DR_PASS:  dr_lsb = byp_q;
      DR_IDENT: dr_lsb = id_lsb;
      default:  dr_lsb = cell_lsb;
    endcase
  end

  assign in_shift = (st_q == ST_IR_SHIFT) || (st_q == ST_DR_SHIFT);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift;
      tdo    <= (st_q == ST_IR_SHIFT) ? ir_sr[0] : dr_lsb;
    end
  end

  assign ovr_sel   = (ir_act == OP_DRIVE);
  assign force_hiz = (ir_act == OP_HIZ);

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk
  import scan_pkg::*;
(
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input tap_state_e st_q,
  input opcode_t    ir_act,
  input opcode_t    ir_sr,
  input dr_sel_e    dr_sel,
  input logic       byp_q,
  input logic       ovr_sel,
  input logic       force_hiz,
  input logic       tdo_oe
);

  logic [2:0] ones_cnt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)             ones_cnt <= '0;
    else if (!tms)           ones_cnt <= '0;
    else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
  end

  // R2
  five_ones_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_cnt == 3'd5) |-> (st_q == ST_RESET));

  // R1
  reset_loads_ident_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st_q == ST_RESET) |=> (ir_act == OP_IDENT));

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st_q == ST_IR_CAP) |=> (ir_sr == IR_CAPTURE));

  // R5
  pass_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st_q == ST_DR_CAP && dr_sel == DR_PASS) |=> (byp_q == 1'b0));

  // R7
  drive_rise_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(ovr_sel) |-> (st_q == ST_IR_UPD));

  // R9
  hiz_rise_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $rose(force_hiz) |-> (st_q == ST_IR_UPD));

  // R10
  tdo_oe_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (st_q == ST_IR_SHIFT || st_q == ST_DR_SHIFT));

  // R11
  ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (st_q != ST_IR_UPD && st_q != ST_RESET) |-> $stable(ir_act));

endmodule

bind scan_port_ctrl scan_port_chk chk_i (
  .tck(tck), .trst_n(trst_n), .tms(tms), .st_q(st_q), .ir_act(ir_act),
  .ir_sr(ir_sr), .dr_sel(dr_sel), .byp_q(byp_q), .ovr_sel(ovr_sel),
  .force_hiz(force_hiz), .tdo_oe(tdo_oe)
);

// File: tb/scan_port_ctrl_tb_top.sv
module scan_port_ctrl_tb_top;

  localparam int          N_PIN = 8;
  localparam int          N_FIX = 2;
  localparam int          N_DRV = 4;
  localparam int          N_CELL = N_PIN + N_FIX;
  localparam logic [1:0]  FIXV  = 2'b10;
  localparam logic [31:0] IDV   = 32'h1A5C_E0B3;

  logic             tck = 1'b0;
  logic             trst_n = 1'b0;
  logic             tms = 1'b1;
  logic             tdi = 1'b0;
  logic [N_PIN-1:0] pin_sense = '0;
  logic             tdo, tdo_oe, ovr_sel, force_hiz;
  logic [N_DRV-1:0] ovr_val;

  always #4 tck = ~tck;

  scan_port_ctrl dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .pin_sense(pin_sense),
    .tdo(tdo), .tdo_oe(tdo_oe), .ovr_sel(ovr_sel), .ovr_val(ovr_val),
    .force_hiz(force_hiz)
  );

  typedef struct { string req; logic [63:0] val; } exp_t;
  exp_t        exp_q[$];
  logic [63:0] act_q[$];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  // snapshots taken just after each falling edge inside step
  logic s_tdo, s_oe, s_sel, s_hiz;

  task automatic expect_val(input string req, input logic [63:0] v);
    exp_t e;
    e.req = req;
    e.val = v;
    exp_q.push_back(e);
  endtask

  task automatic observe(input logic [63:0] v);
    act_q.push_back(v);
  endtask

  task automatic chk_now(input string req, input logic [63:0] act, input logic [63:0] exp);
    expect_val(req, exp);
    observe(act);
  endtask

  // monitor: pairs observed results with queued expectations in order
  initial begin
    forever begin
      @(posedge tck);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        exp_t        e;
        logic [63:0] a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_chk++;
        if (a !== e.val) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", e.req, a, e.val);
        end
      end
    end
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck);
    #1;
    s_tdo = tdo; s_oe = tdo_oe; s_sel = ovr_sel; s_hiz = force_hiz;
    tms = m;
    tdi = d;
    @(posedge tck);
    #1;
  endtask

  // from idle; returns captured bits and override values around update
  task automatic load_ir(input logic [2:0] op, output logic [2:0] cap,
                         output logic pre_sel, output logic post_sel,
                         output logic pre_hiz, output logic post_hiz);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, op[i]);
      cap[i] = s_tdo;
    end
    step(1'b1, 1'b0);          // now in instruction-update state
    pre_sel = ovr_sel;
    pre_hiz = force_hiz;
    step(1'b0, 1'b0);          // falling edge inside update passes here
    post_sel = s_sel;
    post_hiz = s_hiz;
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din,
                         output logic [63:0] dout, output logic oe_all);
    dout = '0;
    oe_all = 1'b1;
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, din[i]);
      dout[i] = s_tdo;
      oe_all = oe_all & s_oe;
    end
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
  endtask

  task automatic report;
    repeat (3) @(posedge tck);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    logic [2:0]  cap;
    logic        ps, qs, ph, qh, oe;
    logic [63:0] dout;
    logic [2:0]  pass_ops [4];
    pass_ops = '{3'b111, 3'b011, 3'b101, 3'b110};

    #21;
    chk_now("R1 tdo_oe in reset", tdo_oe, 0);
    chk_now("R1 ovr_sel in reset", ovr_sel, 0);
    chk_now("R1 force_hiz in reset", force_hiz, 0);
    trst_n = 1'b1;
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk_now("R10 tdo_oe idle", s_oe, 0);

    // R4: identify is the default instruction
    expect_val("R4 id scan", {32'h0, IDV});
    scan_dr(32, 64'h0, dout, oe);
    observe(dout);
    chk_now("R10 tdo_oe during shift", oe, 1);

    // R3 and R5: pass-through plus unassigned opcodes
    foreach (pass_ops[k]) begin
      expect_val("R3 ir capture", 3'b001);
      load_ir(pass_ops[k], cap, ps, qs, ph, qh);
      observe(cap);
      expect_val("R5 pass one-cycle delay", {56'h0, 8'b0110_0100});
      scan_dr(8, 64'h0000_0000_0000_00B2, dout, oe);
      observe(dout);
    end
    // R11: shifting an opcode without reaching update leaves outputs
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b0); step(1'b0, 1'b1); step(1'b1, 1'b0); // exit1 with 3'b010 shifted
    step(1'b0, 1'b0); // pause
    chk_now("R11 hiz unchanged before update", s_hiz, 0);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); // exit2, update, idle
    chk_now("R11 hiz after update", s_hiz, 1);

    // R2: five high mode cycles from a data shift
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk_now("R2 hiz cleared by reset state", s_hiz, 0);
    expect_val("R2 id after reset state", {32'h0, IDV});
    scan_dr(32, 64'h0, dout, oe);
    observe(dout);

    // R6: sample and preload
    pin_sense = 8'hA5;
    load_ir(3'b100, cap, ps, qs, ph, qh);
    expect_val("R6 sample capture", {54'h0, FIXV, 8'hA5});
    scan_dr(N_CELL, 64'h15A, dout, oe);
    observe(dout);
    chk_now("R6 ovr_sel stays low", ovr_sel, 0);
    chk_now("R6 force_hiz stays low", force_hiz, 0);

    // R7: drive opcode applies preloaded pattern
    load_ir(3'b000, cap, ps, qs, ph, qh);
    chk_now("R7 ovr_sel before falling edge", ps, 0);
    chk_now("R7 ovr_sel after falling edge", qs, 1);
    chk_now("R7 ovr_val preloaded", ovr_val, 4'hA);

    // R8: capture under drive opcode
    pin_sense = 8'h3C;
    expect_val("R8 drive capture", {54'h0, FIXV, 8'h3C});
    scan_dr(N_CELL, 64'h005, dout, oe);
    observe(dout);
    chk_now("R7 ovr_val refreshed", ovr_val, 4'h5);

    // R9: high-impedance opcode
    load_ir(3'b010, cap, ps, qs, ph, qh);
    chk_now("R9 hiz before falling edge", ph, 0);
    chk_now("R9 hiz after falling edge", qh, 1);
    chk_now("R9 ovr_sel low", ovr_sel, 0);
    pin_sense = 8'h81;
    expect_val("R9 cells scanned", {54'h0, FIXV, 8'h81});
    scan_dr(N_CELL, 64'h0, dout, oe);
    observe(dout);

    // R1: asynchronous reset mid-cycle
    @(negedge tck);
    #2;
    trst_n = 1'b0;
    #1;
    chk_now("R1 async hiz clear", force_hiz, 0);
    chk_now("R1 async tdo_oe", tdo_oe, 0);
    #1;
    trst_n = 1'b1;
    step(1'b0, 1'b0);
    expect_val("R1 id after async reset", {32'h0, IDV});
    scan_dr(32, 64'h0, dout, oe);
    observe(dout);

    done = 1'b1;
    report();
  end

endmodule